// File: doc/BRIEF.md
# LSB-first serial control and status port

This block is a serial slave for a six-channel output driver. A host frames each transfer with an active-low chip select, toggles a serial clock and shifts a 16-bit control word in on the data-in line. In the same frame the block returns a 16-bit status word on a data-out line. The driver's fault and output logic supplies the status bits and uses the committed control word. The data-out line has a separate enable, so several slaves can share one return wire.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and their edges are detected in the system clock domain. A status snapshot is taken when chip select falls, and its bit 0 (temperature prewarning) is driven at once. A host can therefore read that one bit by pulsing chip select low without clocking, and no register changes. The control register takes the received word only when chip select rises after exactly sixteen falling clock edges.

Top module: `serial_ctrl_port`

## Requirements
- R1: After reset the control register reads 16'hE000 (bits 15, 14 and 13 high, all others low), and the data-out enable is low.
- R2: The data-out enable is low while chip select is high. It goes high when chip select falls and low again when chip select rises.
- R3: When chip select falls, data-out shows status bit 0 (the prewarning input) before any clock edge.
- R4: Data-in is sampled on falling clock edges, bit 0 first. After a 16-edge frame, ctrl_o[0] is status reset, [6:1] are the output enables of channels 0..5, [12:7] the PWM selects of the same channels, [13] open-load detect (low = active), [14] overcurrent shutdown enable and [15] run (low = standby).
- R5: The control register changes only on a rising edge of chip select. It keeps its old value during the frame, including after the 16th bit.
- R6: A frame with any falling-edge count other than 16 leaves the control register unchanged. This includes a chip-select pulse with no clocks and a frame of 17 or more bits.
- R7: Data-out keeps bit 0 through the first rising clock edge of a frame. Each later rising edge moves it to the next bit, bit 0 first. The status word is: [0] prewarning, [6:1] channel status 0..5, [12:7] zero, [13] overload, [14] standby (the inverse of control bit 15), [15] supply fail.
- R8: The status word is captured when chip select falls. Changes on the status inputs during a frame do not reach data-out until the next frame.
- R9: A clock edge seen in the same system-clock cycle as chip select rising is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Data-out drive enable (high = driven, low = high impedance) |
| ctrl_o | output | 16 | Committed control word |
| warn_i | input | 1 | Temperature prewarning |
| drv_stat_i | input | 6 | Per-channel output status |
| ovl_i | input | 1 | Overload flag |
| psf_i | input | 1 | Supply fail flag |

## Verification
Two events can land in the same system-clock cycle: the end of a frame (chip select rising) and a serial clock falling edge. The bench sends a full 16-bit frame, then raises the clock once more. It drops that clock and raises chip select on the same system-clock edge, so both arrive through the synchronisers together. The check passes if the word is still committed, which shows that the stray edge did not make the count 17. A second overlap is a status input changing while the snapshot is being shifted out. The bench changes every status input in the middle of a frame and compares the returned word with the values present when chip select fell.

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] CTRL_INIT   = 16'hE000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n_i,
  input  logic        sclk_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic        sdo_en_o,
  output logic [15:0] ctrl_o,
  input  logic        warn_i,
  input  logic [5:0]  drv_stat_i,
  input  logic        ovl_i,
  input  logic        psf_i
);
  localparam int BITS  = 16;
  localparam int CNT_W = $clog2(BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(BITS + 1);

  logic [SYNC_STAGES-1:0] cs_sy, sclk_sy, sdi_sy;
  logic cs_q, sclk_q;
  logic [BITS-1:0] rx, tx;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy   <= '1;
      sclk_sy <= '0;
      sdi_sy  <= '0;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
    end else begin
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n_i};
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      sdi_sy  <= {sdi_sy[SYNC_STAGES-2:0], sdi_i};
      cs_q    <= cs_sy[SYNC_STAGES-1];
      sclk_q  <= sclk_sy[SYNC_STAGES-1];
    end
  end

  wire cs_s   = cs_sy[SYNC_STAGES-1];
  wire sclk_s = sclk_sy[SYNC_STAGES-1];
  wire sdi_s  = sdi_sy[SYNC_STAGES-1];

  wire cs_fall   = cs_q & ~cs_s;
  wire cs_rise   = ~cs_q & cs_s;
  wire in_frame  = ~cs_q & ~cs_s;
  wire sclk_fall = in_frame & sclk_q & ~sclk_s;
  wire sclk_rise = in_frame & ~sclk_q & sclk_s;

  wire [BITS-1:0] status_word = {psf_i, ~ctrl_o[15], ovl_i, 6'b000000, drv_stat_i, warn_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= CTRL_INIT;
      rx       <= '0;
      tx       <= '0;
      cnt      <= '0;
      sdo_o    <= 1'b0;
      sdo_en_o <= 1'b0;
    end else if (cs_fall) begin
      tx       <= status_word;
      sdo_o    <= status_word[0];
      sdo_en_o <= 1'b1;
      cnt      <= '0;
    end else if (cs_rise) begin
      sdo_en_o <= 1'b0;
      if (cnt == CNT_FULL) ctrl_o <= rx;
    end else begin
      if (sclk_fall) begin
        rx <= {sdi_s, rx[BITS-1:1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
      if (sclk_rise && cnt != '0) begin
        tx    <= {1'b0, tx[BITS-1:1]};
        sdo_o <= tx[1];
      end
    end
  end

  a_r2_dout_released: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sdo_en_o);

  a_r3_peek_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (sdo_en_o && sdo_o == $past(warn_i)));

  a_r5_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_o) |-> $past(cs_rise));

  a_r6_discard_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != CNT_FULL) |=> $stable(ctrl_o));

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);

  a_r7_first_rise_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && cnt == '0 && !cs_fall) |=> $stable(sdo_o));
endmodule

// File: tb/serial_ctrl_port_tb.sv
module serial_ctrl_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  logic [15:0] ctrl;
  logic warn = 1'b0, ovl = 1'b0, psf = 1'b0;
  logic [5:0] drv = '0;
  int checks = 0, errors = 0;
  logic [15:0] exp_ctrl = 16'hE000;
  bit done = 1'b0;
  localparam int H = 6;

  always #4 clk = ~clk;

  serial_ctrl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .ctrl_o(ctrl),
    .warn_i(warn), .drv_stat_i(drv), .ovl_i(ovl), .psf_i(psf)
  );

  function automatic logic [15:0] stat_exp(logic w, logic [5:0] d, logic o, logic p, logic [15:0] c);
    return {p, ~c[15], o, 6'b000000, d, w};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit mid_change,
                       output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    wait_clk(H);
    chk("R2 enable in frame", {15'b0, sdo_en}, 16'h0001);
    chk("R3 bit0 before clock", {15'b0, sdo}, {15'b0, warn});
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[i] : 1'b1;
      sclk = 1'b1;
      wait_clk(H);
      if (i < 16) rd[i] = sdo;
      if (mid_change && i == 5) begin
        warn = ~warn; drv = ~drv; ovl = ~ovl; psf = ~psf;
      end
      sclk = 1'b0;
      wait_clk(H);
    end
    chk("R5 held before cs rise", ctrl, exp_ctrl);
    cs_n = 1'b1;
    wait_clk(H);
    chk("R2 released", {15'b0, sdo_en}, 16'h0000);
    if (nbits == 16) exp_ctrl = w;
  endtask

  initial begin
    logic [15:0] rd, w, se;
    void'($urandom(32'd1234));
    wait_clk(3);
    chk("R1 ctrl reset", ctrl, 16'hE000);
    chk("R1 enable reset", {15'b0, sdo_en}, 16'h0000);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R2 idle enable", {15'b0, sdo_en}, 16'h0000);

    warn = 1'b1; drv = 6'b101101; ovl = 1'b1; psf = 1'b0;
    se = stat_exp(warn, drv, ovl, psf, exp_ctrl);
    frame(16'hA5C3, 16, 1'b0, rd);
    chk("R4 directed commit", ctrl, 16'hA5C3);
    chk("R7 directed readback", rd, se);

    cs_n = 1'b0;
    warn = 1'b0;
    wait_clk(H);
    chk("R3 peek bit low", {15'b0, sdo}, 16'h0000);
    cs_n = 1'b1;
    wait_clk(H);
    chk("R6 peek no commit", ctrl, exp_ctrl);
    warn = 1'b1;
    cs_n = 1'b0;
    wait_clk(H);
    chk("R3 peek bit high", {15'b0, sdo}, 16'h0001);
    cs_n = 1'b1;
    wait_clk(H);

    frame(16'h1234, 15, 1'b0, rd);
    chk("R6 short frame discarded", ctrl, 16'hA5C3);
    frame(16'h4321, 17, 1'b0, rd);
    chk("R6 long frame discarded", ctrl, 16'hA5C3);

    warn = 1'b0; drv = 6'b010011; ovl = 1'b0; psf = 1'b1;
    se = stat_exp(warn, drv, ovl, psf, exp_ctrl);
    frame(16'h7FFE, 16, 1'b1, rd);
    chk("R8 snapshot stable", rd, se);
    chk("R4 commit standby", ctrl, 16'h7FFE);
    se = stat_exp(warn, drv, ovl, psf, exp_ctrl);
    frame(16'hFFFF, 16, 1'b0, rd);
    chk("R7 standby bit set", rd, se);

    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < 16; i++) begin
      sdi = i[0];
      sclk = 1'b1; wait_clk(H);
      sclk = 1'b0; wait_clk(H);
    end
    sclk = 1'b1; wait_clk(H);
    sclk = 1'b0; cs_n = 1'b1;
    wait_clk(H);
    chk("R9 coincident edge ignored", ctrl, 16'hAAAA);
    exp_ctrl = 16'hAAAA;

    for (int k = 0; k < 24; k++) begin
      warn = 1'($urandom); drv = 6'($urandom); ovl = 1'($urandom); psf = 1'($urandom);
      w = 16'($urandom);
      se = stat_exp(warn, drv, ovl, psf, exp_ctrl);
      frame(w, 16, (k % 3) == 0, rd);
      chk("R4 random commit", ctrl, w);
      chk("R7 random readback", rd, se);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule